// File: doc/BRIEF.md
# Configuration Port Decoder

This block sits on the I/O request path of a processor. It receives one I/O port access per cycle (port number, access size, write flag and write data) and decides where the access goes. A full 4-byte access to the configuration-address port reads or writes an internal 32-bit address register held in the block. An access to the four-port configuration-data window becomes a configuration-space physical address. That address is built from the stored register, but only while the register's enable bit is set. Every other legal port is forwarded to the I/O space with a fixed physical prefix. A port number wider than 16 bits is reported as an error.

All results are registered and appear one clock after the request. The response carries a target code, the physical address, an address-valid flag, a no-target flag and, for reads of the address register, its contents.

Top module: `cfg_port_decoder`

## Requirements
- R1: After a synchronous reset, `rsp_valid` is 0 and the stored address register is 0x0000_0000. A 4-byte read of port 0xCF8 returns 0 and a data-window access gets no target.
- R2: A request whose port has any bit above bit 15 set gives target code 4 (error), `rsp_addr_ok` = 0 and `rsp_paddr` = 0. It never changes the stored register.
- R3: A request to port 0xCF8 of size exactly 4 gives target code 1 (address register) and `rsp_paddr` = 0x00_0000_0010. A write loads `req_wdata` into the register on that clock edge. A read returns the register value on `rsp_rdata`; in every other case `rsp_rdata` is 0.
- R4: A request to port 0xCF8 with a size other than 4 is forwarded as an I/O-space access (R7) and does not change the register.
- R5: A request to ports 0xCFC–0xCFF while register bit 31 is 1 gives target code 2 (configuration space). `rsp_paddr` = 0x40_0000_0000 | (register bits 30..2 in place) | port bits 1..0, with `rsp_addr_ok` = 1.
- R6: A data-window request while register bit 31 is 0 gives target code 0, `rsp_no_target` = 1, `rsp_addr_ok` = 0 and `rsp_paddr` = 0.
- R7: Any other port gives target code 3 (I/O space), `rsp_paddr` = 0x20_0000_0000 | port, `rsp_addr_ok` = 1.
- R8: Every response appears exactly one clock after its request, and `rsp_valid` follows `req_valid`. A cycle with no request gives `rsp_valid` = 0, target 0, and all flags and data 0.
- R9: Only a 4-byte write to port 0xCF8 with a legal port changes the stored register. Writes to the data window or to I/O ports leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_port | input | 32 | Port number; only bits 15..0 may be set |
| req_size | input | 3 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_target | output | 3 | 0 none, 1 address register, 2 configuration space, 3 I/O space, 4 error |
| rsp_paddr | output | 40 | Physical address of the target |
| rsp_addr_ok | output | 1 | `rsp_paddr` is meaningful |
| rsp_no_target | output | 1 | Data-window access with enable bit clear |
| rsp_rdata | output | 32 | Address register contents on a read of it |

## Verification
The hardest cases to reach from the ports are the ones that sit just outside the register-write condition: a port that matches 0xCF8 in its low 16 bits but has a high bit set, a 0xCF8 access of size 2, and writes to the data window. Each of these must leave the register untouched, and that can only be seen by reading the register back or probing the data window afterwards. The stimulus therefore follows every such near-miss with a 4-byte read of 0xCF8 and a window access. A long random phase then biases ports toward 0xCF8, the window and its two neighbours, toggles the enable bit through real register writes, and compares every clock against a behavioural model.

// File: rtl/cfg_port_decoder_pkg.sv
package cfg_port_decoder_pkg;

  typedef enum logic [2:0] {
    TGT_NONE     = 3'd0,
    TGT_ADDRREG  = 3'd1,
    TGT_CFGSPACE = 3'd2,
    TGT_IOSPACE  = 3'd3,
    TGT_ERROR    = 3'd4
  } tgt_e;

  localparam int TGT_W = 3;

endpackage

// File: rtl/cfg_port_classify.sv
module cfg_port_classify
  import cfg_port_decoder_pkg::*;
#(
  parameter int          PORT_IN_W = 32,
  parameter int          IO_W      = 16,
  parameter int          SIZE_W    = 3,
  parameter logic [15:0] ADDR_PORT = 16'hCF8,
  parameter logic [15:0] WIN_BASE  = 16'hCFC
) (
  input  logic                 valid,
  input  logic [PORT_IN_W-1:0] port,
  input  logic [SIZE_W-1:0]    size,
  input  logic                 write,
  input  logic                 enable_bit,
  output tgt_e                 target,
  output logic                 no_target,
  output logic                 load
);
  localparam logic [IO_W-1:0] WIN_MASK = ~IO_W'(3);
  localparam logic [IO_W-1:0] APORT    = IO_W'(ADDR_PORT);
  localparam logic [IO_W-1:0] WBASE    = IO_W'(WIN_BASE);
  localparam logic [SIZE_W-1:0] FULL_SZ = SIZE_W'(4);

  logic            high_err;
  logic [IO_W-1:0] lo;
  logic            hit_areg;
  logic            hit_win;

  assign high_err = |port[PORT_IN_W-1:IO_W];
  assign lo       = port[IO_W-1:0];
  assign hit_areg = (lo == APORT) && (size == FULL_SZ);
  assign hit_win  = ((lo & WIN_MASK) == WBASE);

  always_comb begin
    target    = TGT_NONE;
    no_target = 1'b0;
    if (valid) begin
      if (high_err) begin
        target = TGT_ERROR;
      end else if (hit_areg) begin
        target = TGT_ADDRREG;
      end else if (hit_win) begin
        if (enable_bit) begin
          target = TGT_CFGSPACE;
        end else begin
          target    = TGT_NONE;
          no_target = 1'b1;
        end
      end else begin
        target = TGT_IOSPACE;
      end
    end
  end

  assign load = valid && !high_err && hit_areg && write;

endmodule

// File: rtl/cfg_addr_store.sv
module cfg_addr_store #(
  parameter int          REG_W   = 32,
  parameter logic [31:0] RST_VAL = 32'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst) begin
      value <= REG_W'(RST_VAL);
    end else if (load) begin
      value <= wdata;
    end
  end

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(value));

  // R3
  load_takes_data_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (value == $past(wdata)));

endmodule

// File: rtl/cfg_addr_form.sv
module cfg_addr_form
  import cfg_port_decoder_pkg::*;
#(
  parameter int          IO_W        = 16,
  parameter int          REG_W       = 32,
  parameter int          PA_W        = 40,
  parameter logic [39:0] CFG_PREFIX  = 40'h40_0000_0000,
  parameter logic [39:0] IO_PREFIX   = 40'h20_0000_0000,
  parameter logic [39:0] AREG_PADDR  = 40'h00_0000_0010
) (
  input  tgt_e             target,
  input  logic [IO_W-1:0]  port_lo,
  input  logic [REG_W-2:2] cfg_bits,
  output logic [PA_W-1:0]  paddr,
  output logic             addr_ok
);
  localparam int CFG_OFS_W = REG_W - 1;

  logic [PA_W-1:0] cfg_addr;
  logic [PA_W-1:0] io_addr;

  assign cfg_addr = PA_W'(CFG_PREFIX)
                  | PA_W'({cfg_bits, port_lo[1:0]});
  assign io_addr  = PA_W'(IO_PREFIX) | PA_W'(port_lo);

  always_comb begin
    paddr   = '0;
    addr_ok = 1'b0;
    unique case (target)
      TGT_ADDRREG: begin
        paddr   = PA_W'(AREG_PADDR);
        addr_ok = 1'b1;
      end
      TGT_CFGSPACE: begin
        paddr   = cfg_addr;
        addr_ok = 1'b1;
      end
      TGT_IOSPACE: begin
        paddr   = io_addr;
        addr_ok = 1'b1;
      end
      default: begin
        paddr   = '0;
        addr_ok = 1'b0;
      end
    endcase
  end

  // R5
  cfg_offset_width_chk: assert final (CFG_OFS_W <= PA_W);

endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_port_decoder_pkg::*;
#(
  parameter int          PORT_IN_W  = 32,
  parameter int          IO_W       = 16,
  parameter int          SIZE_W     = 3,
  parameter int          REG_W      = 32,
  parameter int          PA_W       = 40,
  parameter logic [15:0] ADDR_PORT  = 16'hCF8,
  parameter logic [15:0] WIN_BASE   = 16'hCFC,
  parameter logic [39:0] CFG_PREFIX = 40'h40_0000_0000,
  parameter logic [39:0] IO_PREFIX  = 40'h20_0000_0000,
  parameter logic [39:0] AREG_PADDR = 40'h00_0000_0010
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [PORT_IN_W-1:0] req_port,
  input  logic [SIZE_W-1:0]    req_size,
  input  logic                 req_write,
  input  logic [REG_W-1:0]     req_wdata,
  output logic                 rsp_valid,
  output logic [TGT_W-1:0]     rsp_target,
  output logic [PA_W-1:0]      rsp_paddr,
  output logic                 rsp_addr_ok,
  output logic                 rsp_no_target,
  output logic [REG_W-1:0]     rsp_rdata
);
  localparam int EN_BIT = REG_W - 1;

  tgt_e             c_target;
  logic             c_no_target;
  logic             c_load;
  logic [REG_W-1:0] areg;
  logic [PA_W-1:0]  c_paddr;
  logic             c_addr_ok;
  logic [REG_W-1:0] c_rdata;

  cfg_port_classify #(
    .PORT_IN_W (PORT_IN_W),
    .IO_W      (IO_W),
    .SIZE_W    (SIZE_W),
    .ADDR_PORT (ADDR_PORT),
    .WIN_BASE  (WIN_BASE)
  ) u_classify (
    .valid      (req_valid),
    .port       (req_port),
    .size       (req_size),
    .write      (req_write),
    .enable_bit (areg[EN_BIT]),
    .target     (c_target),
    .no_target  (c_no_target),
    .load       (c_load)
  );

  cfg_addr_store #(
    .REG_W   (REG_W),
    .RST_VAL (32'h0)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .load  (c_load),
    .wdata (req_wdata),
    .value (areg)
  );

  cfg_addr_form #(
    .IO_W       (IO_W),
    .REG_W      (REG_W),
    .PA_W       (PA_W),
    .CFG_PREFIX (CFG_PREFIX),
    .IO_PREFIX  (IO_PREFIX),
    .AREG_PADDR (AREG_PADDR)
  ) u_form (
    .target   (c_target),
    .port_lo  (req_port[IO_W-1:0]),
    .cfg_bits (areg[REG_W-2:2]),
    .paddr    (c_paddr),
    .addr_ok  (c_addr_ok)
  );

  assign c_rdata = (c_target == TGT_ADDRREG && !req_write) ? areg : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_target    <= TGT_NONE;
      rsp_paddr     <= '0;
      rsp_addr_ok   <= 1'b0;
      rsp_no_target <= 1'b0;
      rsp_rdata     <= '0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_target    <= c_target;
      rsp_paddr     <= c_paddr;
      rsp_addr_ok   <= c_addr_ok;
      rsp_no_target <= c_no_target;
      rsp_rdata     <= c_rdata;
    end
  end

  // R2
  high_port_error_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && |req_port[PORT_IN_W-1:IO_W]) |=>
      (rsp_target == TGT_ERROR && !rsp_addr_ok));

  // R6
  no_target_no_addr_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_no_target |-> (!rsp_addr_ok && rsp_target == TGT_NONE));

  // R8
  idle_response_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_addr_ok && !rsp_no_target));

  // R7
  io_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(|req_port[PORT_IN_W-1:IO_W])
      && req_port[IO_W-1:3] != ADDR_PORT[IO_W-1:3]) |=>
      (rsp_target == TGT_IOSPACE
        && rsp_paddr[IO_W-1:0] == $past(req_port[IO_W-1:0])));

endmodule

// File: tb/sim_cfg_port_decoder.sv
`timescale 1ns/1ps
module sim_cfg_port_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_port = '0;
  logic [2:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_target;
  logic [39:0] rsp_paddr;
  logic        rsp_addr_ok;
  logic        rsp_no_target;
  logic [31:0] rsp_rdata;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] model_reg = 32'h0;

  localparam logic [39:0] CFGP = 40'h40_0000_0000;
  localparam logic [39:0] IOP  = 40'h20_0000_0000;
  localparam logic [39:0] AREGP = 40'h00_0000_0010;

  always #2 clk = ~clk;

  cfg_port_decoder u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_port(req_port),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_paddr(rsp_paddr),
    .rsp_addr_ok(rsp_addr_ok), .rsp_no_target(rsp_no_target),
    .rsp_rdata(rsp_rdata)
  );

  task automatic compare(input string tag, input logic ev, input logic [2:0] et,
                         input logic [39:0] ep, input logic eok, input logic enf,
                         input logic [31:0] ed);
    vectors++;
    if (rsp_valid !== ev || rsp_target !== et || rsp_paddr !== ep ||
        rsp_addr_ok !== eok || rsp_no_target !== enf || rsp_rdata !== ed) begin
      miscompares++;
      $display("FAIL %s: act v=%0b t=%0d pa=%h ok=%0b nt=%0b rd=%h exp v=%0b t=%0d pa=%h ok=%0b nt=%0b rd=%h",
               tag, rsp_valid, rsp_target, rsp_paddr, rsp_addr_ok, rsp_no_target,
               rsp_rdata, ev, et, ep, eok, enf, ed);
    end
  endtask

  // Drive at a falling edge, then check at the next falling edge.
  task automatic apply(input bit v, input logic [31:0] p, input logic [2:0] sz,
                       input bit w, input logic [31:0] d);
    string tag;
    logic [2:0] et; logic [39:0] ep; logic eok, enf; logic [31:0] ed;
    req_valid = v; req_port = p; req_size = sz; req_write = w; req_wdata = d;
    et = 3'd0; ep = '0; eok = 0; enf = 0; ed = '0; tag = "R8";
    if (v) begin
      if (p[31:16] != 0) begin
        tag = "R2"; et = 3'd4;
      end else if (p[15:0] == 16'hCF8 && sz == 3'd4) begin
        tag = "R3"; et = 3'd1; ep = AREGP; eok = 1;
        if (!w) ed = model_reg;
      end else if (p[15:0] >= 16'hCFC && p[15:0] <= 16'hCFF) begin
        if (model_reg[31]) begin
          tag = "R5"; et = 3'd2; eok = 1;
          ep = CFGP + 40'(model_reg & 32'h7FFF_FFFC) + 40'(p[1:0]);
        end else begin
          tag = "R6"; enf = 1;
        end
      end else begin
        tag = (p[15:0] == 16'hCF8) ? "R4" : "R7";
        et = 3'd3; eok = 1; ep = IOP + 40'(p[15:0]);
      end
    end
    @(negedge clk);
    compare(tag, v, et, ep, eok, enf, ed);
    if (v && p[31:16] == 0 && p[15:0] == 16'hCF8 && sz == 3'd4 && w)
      model_reg = d;
  endtask

  task automatic readback(input string tag, input logic [31:0] exp);
    apply(1, 32'hCF8, 3'd4, 0, 32'h0);
    if (rsp_rdata !== exp) $display("FAIL %s: readback act %h exp %h", tag, rsp_rdata, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1: outputs cleared during reset
    compare("R1", 0, 3'd0, '0, 0, 0, '0);
    model_reg = 32'h0;
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1 / R8: idle, then read of cleared register, window gets no target
    apply(0, 32'h0, 3'd0, 0, 32'h0);
    apply(1, 32'hCF8, 3'd4, 0, 32'h0);
    apply(1, 32'hCFD, 3'd1, 0, 32'h0);
    // R3: write then read back
    apply(1, 32'hCF8, 3'd4, 1, 32'h8000_1234);
    apply(1, 32'hCF8, 3'd4, 0, 32'h0);
    // R5: all four window ports
    for (int k = 0; k < 4; k++) apply(1, 32'hCFC + k, 3'd4, 0, 32'h0);
    // R4: narrow access to 0xCF8 forwarded, register unchanged
    apply(1, 32'hCF8, 3'd2, 1, 32'h0000_0000);
    apply(1, 32'hCF8, 3'd1, 0, 32'h0);
    readback("R4", 32'h8000_1234);
    // R2: high port bit on a would-be register write
    apply(1, 32'h0001_0CF8, 3'd4, 1, 32'h0);
    apply(1, 32'h8000_0080, 3'd1, 0, 32'h0);
    readback("R2", 32'h8000_1234);
    // R9: window write and I/O write leave register unchanged
    apply(1, 32'hCFE, 3'd4, 1, 32'hFFFF_FFFF);
    apply(1, 32'h0080, 3'd4, 1, 32'h1111_1111);
    readback("R9", 32'h8000_1234);
    // R7: neighbours of the special ports
    apply(1, 32'hCFB, 3'd1, 0, 32'h0);
    apply(1, 32'hCF9, 3'd4, 0, 32'h0);
    apply(1, 32'hD00, 3'd2, 0, 32'h0);
    apply(1, 32'hFFFF, 3'd1, 1, 32'h0);
    apply(1, 32'h0000, 3'd4, 0, 32'h0);
    // R6: enable clear, other bits set
    apply(1, 32'hCF8, 3'd4, 1, 32'h7FFF_FFFF);
    apply(1, 32'hCFF, 3'd4, 0, 32'h0);
    // R5: enable set, all offset bits set
    apply(1, 32'hCF8, 3'd4, 1, 32'hFFFF_FFFF);
    apply(1, 32'hCFF, 3'd4, 1, 32'h0);
    // random phase, ports biased toward the decoded area
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] p;
      int sel;
      sel = $urandom_range(0, 9);
      case (sel)
        0, 1: p = 32'hCF8;
        2, 3: p = 32'hCFC + 32'($urandom_range(0, 3));
        4:    p = 32'hCF4 + 32'($urandom_range(0, 3));
        5:    p = 32'hD00 + 32'($urandom_range(0, 3));
        6:    p = {16'h0001 << $urandom_range(0, 15), 16'hCF8};
        default: p = {16'h0, 16'($urandom)};
      endcase
      apply($urandom_range(0, 7) != 0, p,
            ($urandom_range(0, 2) != 0) ? 3'd4 : 3'($urandom_range(1, 2)),
            $urandom_range(0, 1) == 1, $urandom);
    end
    // R1: reset in mid-run clears the register
    apply(1, 32'hCF8, 3'd4, 1, 32'h8000_00F0);
    do_reset();
    apply(1, 32'hCF8, 3'd4, 0, 32'h0);
    apply(1, 32'hCFC, 3'd4, 0, 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule